// File: doc/BRIEF.md
# Add-only memory command controller

This block is the memory-function layer of a single-wire slave that holds a 128-byte one-time-programmable data array and an 8-byte status array. A bit-level engine hands it each received byte on `rx_valid`/`rx_byte`. It asks for each outgoing byte with a one-cycle `tx_req`, which stands for eight read slots. The block decodes a command byte and a two-byte start address, echoes a CRC-8 of what it received, and then either streams array contents or runs a byte-programming loop.

Both arrays are modelled in registers whose bits can only be cleared. A program byte is staged in a scratchpad. It is committed, ANDed into the addressed byte, when `prog_pulse` arrives. That input stands in for the high-voltage programming pulse. The device never checks a CRC itself: after each echo the master alone decides whether to pulse, read on, or issue a line reset.

The controller is one state machine:
- CMD → ADLO → ADHI receive the command and address. An unknown command goes from CMD to ONES.
- Writes go ADHI → WDATA → ECHO → PROG → VERIFY → WDATA, and so on.
- Reads go ADHI → ECHO → READ → TAIL. TAIL then goes either back to READ, for the next page, or on to ONES.
- A line reset takes any state back to CMD.

Top module: `aom_ctrl`

## Requirements
- R1: After `rst_n` is released, `tx_valid` is low, every data byte reads FFh, status bytes 0..6 read FFh and status byte 7 reads 00h.
- R2: The command and the address are received in this order: command, address low byte, address high byte, all bytes LSB first. The first requested byte is then the CRC-8 (polynomial x^8+x^5+x^4+1 processed LSB first as reflected constant 8Ch, initial value 00h) of those three bytes. For the write commands (0Fh data, 55h status) the CRC also covers the data byte that follows the address.
- R3: Command F0h streams data bytes from the start address up to address 127. The next byte is the CRC-8 (initial 00h) of all data bytes streamed. Every later byte is FFh.
- R4: Command C3h streams data like F0h, but after the last byte of each 32-byte page it returns a CRC-8 of the bytes read in that page and then continues at the next page. After the CRC of page 3 it returns FFh.
- R5: Command AAh streams status bytes from the start address to byte 7, then their CRC-8, then FFh.
- R6: When `prog_pulse` is received after the echo CRC of a write, the addressed byte becomes its old value ANDed with the data byte. The next requested byte returns the stored byte.
- R7: After that verify byte the address increments. The CRC register is loaded with the low byte of the new address, and the next data byte is shifted into it. The next requested byte returns that CRC, and the loop repeats.
- R8: For the write commands the start address keeps only its 7 low bits: the upper 9 bits are forced to zero before they enter the CRC and the address counter.
- R9: A data byte in a page whose bit in status byte 0 is 0 (bit p guards page p, bytes 32p..32p+31) is left unchanged by a program pulse. That page still reads normally.
- R10: A `prog_pulse` is ignored, leaving both arrays unchanged, unless it arrives after the echo CRC of a write and before that byte's verify read. Only one pulse takes effect per byte.
- R11: `line_reset` returns the controller to waiting for a command and drops `tx_valid`. Array contents are kept.
- R12: After a command byte other than F0h, AAh, C3h, 0Fh and 55h, further received bytes are ignored and every requested byte is FFh.
- R13: `tx_valid` pulses for exactly one cycle, the cycle after a `tx_req`, and never at other times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; erases the array model |
| line_reset | input | 1 | Bus reset pulse seen by the bit engine |
| rx_valid | input | 1 | A byte from the master is present |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Master requests one byte (eight read slots) |
| prog_pulse | input | 1 | Programming voltage detected |
| tx_valid | output | 1 | `tx_byte` holds the requested byte |
| tx_byte | output | 8 | Byte returned to the master |

## Verification
Every returned byte is due in the cycle right after its `tx_req`, registered once, and nothing else takes a cycle. The bench raises `tx_req` on a falling edge, pushes the expected byte into a scoreboard queue, and samples `tx_valid` one falling edge later. The queue must be empty half a cycle after that, and any `tx_valid` with no pending entry is a failure. Program pulses and received bytes take effect at the next rising edge, so each verify read is requested at least one full cycle after its pulse.

// File: rtl/aom_pkg.sv
package aom_pkg;

    localparam logic [7:0] CMD_RD_DATA = 8'hF0;
    localparam logic [7:0] CMD_RD_STAT = 8'hAA;
    localparam logic [7:0] CMD_RD_PAGE = 8'hC3;
    localparam logic [7:0] CMD_WR_DATA = 8'h0F;
    localparam logic [7:0] CMD_WR_STAT = 8'h55;

    typedef enum logic [3:0] {
        ST_CMD,
        ST_ADLO,
        ST_ADHI,
        ST_WDATA,
        ST_ECHO,
        ST_READ,
        ST_TAIL,
        ST_ONES,
        ST_PROG,
        ST_VERIFY
    } aom_state_t;

    function automatic logic cmd_known(input logic [7:0] c);
        return (c == CMD_RD_DATA) || (c == CMD_RD_STAT) || (c == CMD_RD_PAGE) ||
               (c == CMD_WR_DATA) || (c == CMD_WR_STAT);
    endfunction

    // One byte through the reflected x^8+x^5+x^4+1 shift register, LSB first.
    function automatic logic [7:0] crc8_byte(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

endpackage

// File: rtl/aom_crc8.sv
module aom_crc8 (
    input  logic [7:0] crc_in,
    input  logic [7:0] data_in,
    output logic [7:0] crc_out
);
    assign crc_out = aom_pkg::crc8_byte(crc_in, data_in);
endmodule

// File: rtl/aom_otp_array.sv
module aom_otp_array #(
    parameter int         NBYTES    = 8,
    parameter logic [7:0] LAST_INIT = 8'hFF
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  wr_en,
    input  logic [IW-1:0]         wr_idx,
    input  logic [7:0]            wr_mask,
    input  logic [IW-1:0]         rd_idx,
    output logic [7:0]            rd_byte,
    output logic [NBYTES*8-1:0]   image
);
    localparam int IW = $clog2(NBYTES);

    logic [7:0] cells [NBYTES];

    for (genvar i = 0; i < NBYTES; i++) begin : g_cell
        localparam logic [7:0] INIT = (i == NBYTES - 1) ? LAST_INIT : 8'hFF;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)
                cells[i] <= INIT;
            else if (wr_en && wr_idx == IW'(i))
                cells[i] <= cells[i] & wr_mask;
        end
        assign image[i*8 +: 8] = cells[i];
    end

    assign rd_byte = cells[rd_idx];
endmodule

// File: rtl/aom_ctrl.sv
module aom_ctrl #(
    parameter int DATA_BYTES = 128,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       line_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       prog_pulse,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    import aom_pkg::*;

    localparam int          DAW      = $clog2(DATA_BYTES);
    localparam int          SAW      = $clog2(STAT_BYTES);
    localparam int          PAW      = $clog2(PAGE_BYTES);
    localparam logic [16:0] DATA_LEN = 17'(DATA_BYTES);
    localparam logic [16:0] STAT_LEN = 17'(STAT_BYTES);
    localparam logic [15:0] WR_KEEP  = 16'((32'd1 << DAW) - 1);

    aom_state_t  state_q, st_d;
    logic [7:0]  cmd_q, cmd_d;
    logic [15:0] addr_q, addr_d, addr_inc;
    logic [7:0]  scratch_q, scr_d;
    logic [7:0]  crc_q, crc_d, crc_src, crc_dat, crc_nx;
    logic        tx_valid_q, txv_d;
    logic [7:0]  tx_byte_q, txb_d;
    logic        data_we, stat_we, do_verify;

    logic [7:0]                data_rd, stat_rd, cur_byte;
    logic [DATA_BYTES*8-1:0]   data_img;
    logic [STAT_BYTES*8-1:0]   stat_img;

    logic        is_write, is_stat, is_page;
    logic [16:0] field_len;
    logic        in_range, last_byte, page_end, locked;

    aom_otp_array #(.NBYTES(DATA_BYTES), .LAST_INIT(8'hFF)) u_data (
        .clk(clk), .rst_n(rst_n), .wr_en(data_we), .wr_idx(addr_q[DAW-1:0]),
        .wr_mask(scratch_q), .rd_idx(addr_q[DAW-1:0]), .rd_byte(data_rd),
        .image(data_img)
    );

    aom_otp_array #(.NBYTES(STAT_BYTES), .LAST_INIT(8'h00)) u_stat (
        .clk(clk), .rst_n(rst_n), .wr_en(stat_we), .wr_idx(addr_q[SAW-1:0]),
        .wr_mask(scratch_q), .rd_idx(addr_q[SAW-1:0]), .rd_byte(stat_rd),
        .image(stat_img)
    );

    aom_crc8 u_crc (.crc_in(crc_src), .data_in(crc_dat), .crc_out(crc_nx));

    always_comb begin
        is_write  = (cmd_q == CMD_WR_DATA) || (cmd_q == CMD_WR_STAT);
        is_stat   = (cmd_q == CMD_RD_STAT) || (cmd_q == CMD_WR_STAT);
        is_page   = (cmd_q == CMD_RD_PAGE);
        field_len = is_stat ? STAT_LEN : DATA_LEN;
        in_range  = {1'b0, addr_q} < field_len;
        last_byte = {1'b0, addr_q} == field_len - 17'd1;
        page_end  = &addr_q[PAW-1:0];
        locked    = ~stat_img[addr_q[DAW-1:PAW]];
        cur_byte  = !in_range ? 8'hFF : (is_stat ? stat_rd : data_rd);
        addr_inc  = addr_q + 16'd1;
    end

    // Next-state and datapath decisions.
    always_comb begin
        st_d      = state_q;
        cmd_d     = cmd_q;
        addr_d    = addr_q;
        scr_d     = scratch_q;
        crc_d     = crc_q;
        txv_d     = 1'b0;
        txb_d     = tx_byte_q;
        crc_src   = crc_q;
        crc_dat   = rx_byte;
        data_we   = 1'b0;
        stat_we   = 1'b0;
        do_verify = 1'b0;
        unique case (state_q)
            ST_CMD: if (rx_valid) begin
                cmd_d   = rx_byte;
                crc_src = 8'h00;
                crc_d   = crc_nx;
                st_d    = cmd_known(rx_byte) ? ST_ADLO : ST_ONES;
            end
            ST_ADLO: if (rx_valid) begin
                crc_dat      = is_write ? (rx_byte & WR_KEEP[7:0]) : rx_byte;
                crc_d        = crc_nx;
                addr_d[7:0]  = crc_dat;
                st_d         = ST_ADHI;
            end
            ST_ADHI: if (rx_valid) begin
                crc_dat      = is_write ? (rx_byte & WR_KEEP[15:8]) : rx_byte;
                crc_d        = crc_nx;
                addr_d[15:8] = crc_dat;
                st_d         = is_write ? ST_WDATA : ST_ECHO;
            end
            ST_WDATA: if (rx_valid) begin
                scr_d = rx_byte;
                crc_d = crc_nx;
                st_d  = ST_ECHO;
            end
            ST_ECHO: if (tx_req) begin
                txv_d = 1'b1;
                txb_d = crc_q;
                if (is_write) begin
                    st_d = ST_PROG;
                end else begin
                    crc_d = 8'h00;
                    st_d  = in_range ? ST_READ : ST_TAIL;
                end
            end
            ST_READ: if (tx_req) begin
                txv_d   = 1'b1;
                txb_d   = cur_byte;
                crc_dat = cur_byte;
                crc_d   = crc_nx;
                addr_d  = addr_inc;
                if (last_byte || (is_page && page_end)) st_d = ST_TAIL;
            end
            ST_TAIL: if (tx_req) begin
                txv_d = 1'b1;
                txb_d = crc_q;
                crc_d = 8'h00;
                st_d  = (is_page && in_range) ? ST_READ : ST_ONES;
            end
            ST_ONES: if (tx_req) begin
                txv_d = 1'b1;
                txb_d = 8'hFF;
            end
            ST_PROG: begin
                if (prog_pulse) begin
                    data_we = !is_stat && in_range && !locked;
                    stat_we = is_stat && in_range;
                    st_d    = ST_VERIFY;
                end else if (tx_req) begin
                    do_verify = 1'b1;
                end
            end
            ST_VERIFY: if (tx_req) do_verify = 1'b1;
            default: st_d = ST_CMD;
        endcase
        if (do_verify) begin
            txv_d  = 1'b1;
            txb_d  = cur_byte;
            addr_d = addr_inc;
            crc_d  = addr_inc[7:0];
            st_d   = ST_WDATA;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q    <= ST_CMD;
            cmd_q      <= 8'h00;
            addr_q     <= 16'h0000;
            scratch_q  <= 8'hFF;
            crc_q      <= 8'h00;
            tx_valid_q <= 1'b0;
            tx_byte_q  <= 8'hFF;
        end else if (line_reset) begin
            state_q    <= ST_CMD;
            tx_valid_q <= 1'b0;
        end else begin
            state_q    <= st_d;
            cmd_q      <= cmd_d;
            addr_q     <= addr_d;
            scratch_q  <= scr_d;
            crc_q      <= crc_d;
            tx_valid_q <= txv_d;
            tx_byte_q  <= txb_d;
        end
    end

    assign tx_valid = tx_valid_q;
    assign tx_byte  = tx_byte_q;
endmodule

// File: rtl/aom_ctrl_chk.sv
module aom_ctrl_chk #(
    parameter int DATA_BYTES = 128,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8
) (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    line_reset,
    input logic                    tx_req,
    input logic                    tx_valid,
    input logic                    prog_pulse,
    input aom_pkg::aom_state_t     state,
    input logic [DATA_BYTES*8-1:0] data_img,
    input logic [STAT_BYTES*8-1:0] stat_img
);
    import aom_pkg::*;

    localparam int PAGES = DATA_BYTES / PAGE_BYTES;
    localparam int PW    = PAGE_BYTES * 8;

    // R13: a returned byte always answers a request one cycle earlier.
    a_r13_tx_answers_req: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req));

    // R6: programming only clears bits.
    a_r6_data_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (data_img & ~$past(data_img)) == '0);

    a_r6_stat_only_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_img & ~$past(stat_img)) == '0);

    // R10: array contents change only on a pulse inside the program window.
    a_r10_change_needs_window: assert property (@(posedge clk) disable iff (!rst_n)
        ((data_img != $past(data_img)) || (stat_img != $past(stat_img))) |->
        ($past(state == ST_PROG) && $past(prog_pulse) && !$past(line_reset)));

    // R11: a line reset leaves the controller waiting for a command.
    a_r11_line_reset_to_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        $past(line_reset) |-> (state == ST_CMD && !tx_valid));

    // R9: a locked page never changes.
    for (genvar p = 0; p < PAGES; p++) begin : g_lock
        a_r9_locked_page_stable: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(stat_img[p]) |-> (data_img[p*PW +: PW] == $past(data_img[p*PW +: PW])));
    end
endmodule

bind aom_ctrl aom_ctrl_chk #(
    .DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES), .STAT_BYTES(STAT_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .tx_req(tx_req),
    .tx_valid(tx_valid), .prog_pulse(prog_pulse), .state(state_q),
    .data_img(data_img), .stat_img(stat_img)
);

// File: tb/aom_ctrl_tb.sv
`timescale 1ns/1ps
module aom_ctrl_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       line_reset = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic       tx_req = 1'b0;
    logic       prog_pulse = 1'b0;
    logic       tx_valid;
    logic [7:0] tx_byte;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    logic [7:0] exp_b [$];
    string      exp_t [$];

    logic [7:0] m_data [128];
    logic [7:0] m_stat [8];
    logic [7:0] cur_cmd;
    int         cur_a;

    always #2.5 clk = ~clk;

    aom_ctrl u_dut (
        .clk(clk), .rst_n(rst_n), .line_reset(line_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    function automatic logic [7:0] bcrc(input logic [7:0] c, input logic [7:0] d);
        logic [7:0] r;
        logic       fb;
        r = c;
        for (int i = 0; i < 8; i++) begin
            fb = r[0] ^ d[i];
            r  = r >> 1;
            if (fb) r = r ^ 8'h8C;
        end
        return r;
    endfunction

    function automatic bit is_stat_cmd(input logic [7:0] c);
        return (c == 8'hAA) || (c == 8'h55);
    endfunction

    function automatic logic [7:0] model_byte(input logic [7:0] c, input int a);
        if (is_stat_cmd(c)) return (a < 8) ? m_stat[a] : 8'hFF;
        return (a < 128) ? m_data[a] : 8'hFF;
    endfunction

    task automatic model_prog(input logic [7:0] d);
        if (is_stat_cmd(cur_cmd)) begin
            if (cur_a < 8) m_stat[cur_a] = m_stat[cur_a] & d;
        end else if (cur_a < 128 && m_stat[0][cur_a / 32]) begin
            m_data[cur_a] = m_data[cur_a] & d;
        end
    endtask

    // Scoreboard monitor.
    always @(negedge clk) begin
        if (tx_valid) begin
            checks++;
            if (exp_b.size() == 0) begin
                errors++;
                $display("FAIL R13 unexpected byte: actual %02h expected none", tx_byte);
            end else begin
                logic [7:0] e;
                string      t;
                e = exp_b.pop_front();
                t = exp_t.pop_front();
                if (tx_byte !== e) begin
                    errors++;
                    $display("FAIL %s: actual %02h expected %02h", t, tx_byte, e);
                end
            end
        end
    end

    task automatic slot(input logic [7:0] e, input string t);
        @(negedge clk);
        tx_req = 1'b1;
        exp_b.push_back(e);
        exp_t.push_back(t);
        @(negedge clk);
        tx_req = 1'b0;
        #1;
        if (exp_b.size() != 0) begin
            checks++;
            errors++;
            $display("FAIL R13 (%s) missing byte: actual none expected %02h", t, e);
            exp_b.delete();
            exp_t.delete();
        end
    endtask

    task automatic send(input logic [7:0] b);
        @(negedge clk);
        rx_valid = 1'b1;
        rx_byte  = b;
        @(negedge clk);
        rx_valid = 1'b0;
    endtask

    task automatic pulse();
        @(negedge clk);
        prog_pulse = 1'b1;
        @(negedge clk);
        prog_pulse = 1'b0;
    endtask

    task automatic lreset();
        @(negedge clk);
        line_reset = 1'b1;
        @(negedge clk);
        line_reset = 1'b0;
    endtask

    task automatic check_quiet(input string t);
        @(negedge clk);
        checks++;
        if (tx_valid !== 1'b0) begin
            errors++;
            $display("FAIL %s: actual tx_valid %0b expected 0", t, tx_valid);
        end
    endtask

    task automatic rd_cmd(input logic [7:0] cmd, input logic [15:0] addr, input int n,
                          input string t);
        logic [7:0] c;
        logic [7:0] b;
        int a, len, phase;
        lreset();
        send(cmd); send(addr[7:0]); send(addr[15:8]);
        c = bcrc(bcrc(bcrc(8'h00, cmd), addr[7:0]), addr[15:8]);
        slot(c, "R2 read echo");
        a     = int'(addr);
        len   = (cmd == 8'hAA) ? 8 : 128;
        phase = (a < len) ? 0 : 1;
        c     = 8'h00;
        for (int k = 0; k < n; k++) begin
            if (phase == 0) begin
                b = model_byte(cmd, a);
                c = bcrc(c, b);
                slot(b, t);
                a++;
                if (a == len || (cmd == 8'hC3 && (a % 32) == 0)) phase = 1;
            end else if (phase == 1) begin
                slot(c, {t, " crc"});
                c = 8'h00;
                phase = (cmd == 8'hC3 && a < len) ? 0 : 2;
            end else begin
                slot(8'hFF, {t, " ones"});
            end
        end
    endtask

    task automatic wr_first(input logic [7:0] cmd, input logic [15:0] addr, input logic [7:0] d,
                            input string ct, input string vt);
        logic [7:0] lo;
        logic [7:0] c;
        lo = addr[7:0] & 8'h7F;
        lreset();
        send(cmd); send(addr[7:0]); send(addr[15:8]); send(d);
        c = bcrc(bcrc(bcrc(bcrc(8'h00, cmd), lo), 8'h00), d);
        slot(c, ct);
        cur_cmd = cmd;
        cur_a   = int'(lo);
        model_prog(d);
        pulse();
        slot(model_byte(cur_cmd, cur_a), vt);
        cur_a++;
    endtask

    task automatic wr_next(input logic [7:0] d, input bit pulse_it, input bit stray,
                           input string ct, input string vt);
        logic [7:0] c;
        if (stray) pulse();
        send(d);
        if (stray) pulse();
        c = bcrc(8'(cur_a), d);
        slot(c, ct);
        if (pulse_it) begin
            model_prog(d);
            pulse();
        end
        slot(model_byte(cur_cmd, cur_a), vt);
        cur_a++;
    endtask

    initial begin
        #500us;
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("  CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 128; i++) m_data[i] = 8'hFF;
        for (int i = 0; i < 8; i++) m_stat[i] = (i == 7) ? 8'h00 : 8'hFF;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        check_quiet("R1 tx_valid after reset");
        send(8'hF0);
        check_quiet("R13 no byte without request");

        // R1 / R3: erased array read near the end, trailing CRC then ones.
        rd_cmd(8'hF0, 16'h007C, 7, "R3 read tail");
        // R1 / R5: erased status field, last byte fixed 00h.
        rd_cmd(8'hAA, 16'h0000, 10, "R5 status erased");

        // R2, R6, R7: first write, then loop at the incremented address.
        wr_first(8'h0F, 16'h0005, 8'hA5, "R2 write echo", "R6 verify");
        wr_next(8'h3C, 1'b1, 1'b0, "R7 loop crc", "R7 loop verify");
        // R10: stray pulses around the data byte, no pulse in window.
        wr_next(8'h00, 1'b0, 1'b1, "R7 loop crc", "R10 stray pulse ignored");
        // R6: AND with earlier contents.
        wr_first(8'h0F, 16'h0005, 8'hF0, "R2 write echo", "R6 AND of writes");

        // R8: upper address bits dropped.
        wr_first(8'h0F, 16'h0190, 8'h00, "R8 masked echo", "R8 masked verify");
        rd_cmd(8'hF0, 16'h0010, 1, "R8 readback");

        // R9: lock page 1 then try to program it.
        wr_first(8'h55, 16'h0000, 8'hFD, "R2 status echo", "R6 status verify");
        wr_first(8'h0F, 16'h0021, 8'h00, "R2 write echo", "R9 locked page");

        // R3: whole data field.
        rd_cmd(8'hF0, 16'h0000, 131, "R3 full read");
        // R4: per-page CRCs from inside page 0.
        rd_cmd(8'hC3, 16'h001E, 2 + 1 + 33 * 3 + 2, "R4 page read");
        // R5: status from byte 6.
        rd_cmd(8'hAA, 16'h0006, 4, "R5 status read");

        // R12: unknown command.
        lreset();
        send(8'h33); send(8'h00); send(8'h00);
        slot(8'hFF, "R12 unknown cmd");
        slot(8'hFF, "R12 unknown cmd");

        // R11: line reset mid stream, new command works.
        lreset();
        send(8'hF0); send(8'h00); send(8'h00);
        slot(bcrc(bcrc(bcrc(8'h00, 8'hF0), 8'h00), 8'h00), "R11 before reset");
        slot(m_data[0], "R11 before reset");
        lreset();
        check_quiet("R11 quiet after line reset");
        rd_cmd(8'hAA, 16'h0007, 3, "R11 after reset");

        repeat (4) @(negedge clk);
        done = 1'b1;
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule